// File: doc/BRIEF.md
# Bidirectional Pin Port with Mode-Dependent Read-Back

This block holds the output latch and configuration of one general-purpose I/O port of up to eight pins. Software writes a data latch, a per-pin direction mask and a per-pin open-drain mask through a small word-select register bus. Reading the data word does not always return what was written. Each bit shows the stored latch only when its pin is a push-pull output. When the pin is an input or an open-drain output, the bit shows the level sampled on the pin.

The pin side takes a raw input vector and passes it through a synchroniser before any read uses it. Per pin, the block produces a drive value and an output-enable. An open-drain pin enables its driver only to pull the line low, and leaves the line floating when its latch is 1. A parameter mask marks which bits exist. The other bits ignore writes, read back as a fixed pattern that is also a parameter, and never drive their pins.

Top module: `gpio_port_reg`

## Requirements
- R1: A write with reg_sel = 0 loads the data latch from wdata on the clock edge, whatever the direction or mode of each pin, including pins that are inputs.
- R2: With reg_sel = 0, a bit whose direction bit is 1 and whose mode bit is 0 (push-pull output) reads as its data latch bit.
- R3: With reg_sel = 0, a bit whose direction bit is 0 (input) reads as pin_in for that bit as it was two clock edges earlier, through a two-flop synchroniser.
- R4: With reg_sel = 0, a bit whose direction bit is 1 and whose mode bit is 1 (open-drain output) reads as the synchronised pin level, not the latch.
- R5: A push-pull output pin has pin_oe = 1 and pin_out equal to its latch bit.
- R6: An open-drain output pin has pin_oe = 1 only while its latch bit is 0, and pin_out is always 0.
- R7: An input pin has pin_oe = 0 and pin_out = 0.
- R8: While reset is asserted and after it is released, the data latch is 00h, all pins are inputs (direction 00h) and push-pull (mode 00h), and pin_oe is 0.
- R9: Bits outside IMPL_MASK ignore writes to every register, read as the matching bit of FIXED_READ at reg_sel = 0 and as 0 at reg_sel = 1 and 2, and have pin_oe = 0.
- R10: rdata is a combinational view of the current state: a read in the same cycle as a write returns the value from before the write, and the new value appears after the clock edge.
- R11: reg_sel = 1 reads and writes the direction mask (1 = output), reg_sel = 2 reads and writes the mode mask (1 = open-drain), and reg_sel = 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 mode, 3 unused |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data of the selected register |
| pin_in | input | WIDTH | Raw pin levels |
| pin_out | output | WIDTH | Per-pin drive value |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
The bench loads the latch while pins are still inputs and then turns them into outputs. A design that drops writes to input pins would show the old latch at that point. It mixes open-drain and push-pull bits in one word. A design that returned the latch for open-drain bits, or enabled their drivers while the latch is 1, would give a wrong read value and a wrong enable mask. It reads during a write to catch a design that forwards the new value early. A second instance with only three implemented bits catches upper bits that take writes or read anything other than the fixed pattern.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = pin_i;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d[s];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

  // Warm-up counter so the latency check never reaches back past reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 2'd3) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  generate
    if (STAGES == 2) begin : g_chk
      a_r3_two_clock_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (sync_o == $past(pin_i, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_sel_e        sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mode_q
);

  localparam logic [WIDTH-1:0] RST_VAL = '0;

  logic [WIDTH-1:0] wmasked;
  logic             data_en;
  logic             dir_en;
  logic             mode_en;

  always_comb begin
    wmasked = wdata & IMPL_MASK;
    data_en = wr_en && (sel == SEL_DATA);
    dir_en  = wr_en && (sel == SEL_DIR);
    mode_en = wr_en && (sel == SEL_MODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= RST_VAL;
      dir_q  <= RST_VAL;
      mode_q <= RST_VAL;
    end else begin
      if (data_en) data_q <= wmasked;
      if (dir_en)  dir_q  <= wmasked;
      if (mode_en) mode_q <= wmasked;
    end
  end

  a_r1_latch_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> (data_q == ($past(wdata) & IMPL_MASK)));

  a_r11_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_DIR) |=> $stable(dir_q));

  a_r11_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_MODE) |=> $stable(mode_q));

  a_r9_unimpl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_q | dir_q | mode_q) & ~IMPL_MASK) == '0);

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK  = '1,
  parameter logic [WIDTH-1:0] FIXED_READ = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] mode_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] drive,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] data_rd
);

  logic [WIDTH-1:0] push_pull;
  logic [WIDTH-1:0] open_drain;

  always_comb begin
    push_pull  = dir_q & ~mode_q & IMPL_MASK;
    open_drain = dir_q &  mode_q & IMPL_MASK;
    drive      = push_pull & data_q;
    oe         = push_pull | (open_drain & ~data_q);
    data_rd    = (IMPL_MASK & ((push_pull & data_q) | (~push_pull & pin_sync)))
               | (~IMPL_MASK & FIXED_READ);
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      a_r6_od_floats_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q[i] && mode_q[i] && data_q[i]) |-> !oe[i]);
      a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[i] |-> !drive[i]);
      a_r7_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_q[i] |-> (!oe[i] && !drive[i]));
      a_r4_od_reads_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (IMPL_MASK[i] && mode_q[i]) |-> (data_rd[i] == pin_sync[i]));
    end
  endgenerate

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK  = '1,
  parameter logic [WIDTH-1:0] FIXED_READ = '0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  localparam int RST_STAGES = 2;

  gpio_sel_e        sel;
  logic             rst_n_s;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] mode_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_rd;

  assign sel = gpio_sel_e'(reg_sel);

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_n_s)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .pin_i (pin_in),
    .sync_o(pin_sync)
  );

  gpio_cfg_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (wdata),
    .data_q(data_q),
    .dir_q (dir_q),
    .mode_q(mode_q)
  );

  gpio_pin_ctrl #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK), .FIXED_READ(FIXED_READ)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .mode_q  (mode_q),
    .pin_sync(pin_sync),
    .drive   (pin_out),
    .oe      (pin_oe),
    .data_rd (data_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = data_rd;
      SEL_DIR:  rdata = dir_q;
      SEL_MODE: rdata = mode_q;
      default:  rdata = '0;
    endcase
  end

  a_r8_reset_quiet: assert property (@(posedge clk) !rst_n_s |-> (pin_oe == '0));

  a_r9_unimpl_no_drive: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pin_oe & ~IMPL_MASK) == '0);

  a_r10_write_lands_next: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && sel == SEL_DIR) |=> (rdata == ($past(wdata) & IMPL_MASK)) || (sel != SEL_DIR));

endmodule

// File: tb/gpio_port_reg_tb_top.sv
module gpio_port_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] reg_sel;
  logic [7:0] wdata;
  logic [7:0] pin_in;
  logic [7:0] rd_w, out_w, oe_w;
  logic [7:0] rd_n, out_n, oe_n;

  int checks = 0;
  int errors = 0;

  logic [7:0] md   [2];
  logic [7:0] mdir [2];
  logic [7:0] mmode[2];
  logic [7:0] pinv;
  localparam logic [7:0] MASK [2] = '{8'hFF, 8'h07};
  localparam logic [7:0] FIX  [2] = '{8'h00, 8'hF0};

  always #5 clk = ~clk;

  gpio_port_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rd_w), .pin_in(pin_in), .pin_out(out_w), .pin_oe(oe_w));

  gpio_port_reg #(.IMPL_MASK(8'h07), .FIXED_READ(8'hF0)) dut_nar_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rd_n), .pin_in(pin_in), .pin_out(out_n), .pin_oe(oe_n));

  function automatic logic [7:0] exp_rd(int k, int s);
    logic [7:0] pp;
    pp = mdir[k] & ~mmode[k];
    case (s)
      0: return (MASK[k] & ((pp & md[k]) | (~pp & pinv))) | (~MASK[k] & FIX[k]);
      1: return mdir[k];
      2: return mmode[k];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_oe(int k);
    return mdir[k] & (~mmode[k] | ~md[k]);
  endfunction

  function automatic logic [7:0] exp_out(int k);
    return mdir[k] & ~mmode[k] & md[k];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(int s, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s[1:0]; wdata = v;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      case (s)
        0: md[k]    = v & MASK[k];
        1: mdir[k]  = v & MASK[k];
        2: mmode[k] = v & MASK[k];
        default: ;
      endcase
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
    pinv = v;
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      reg_sel = s[1:0];
      #1;
      chk(req, rd_w, exp_rd(0, s));
      chk({req, " narrow"}, rd_n, exp_rd(1, s));
    end
    chk({req, " oe"}, oe_w, exp_oe(0));
    chk({req, " out"}, out_w, exp_out(0));
    chk({req, " oe narrow"}, oe_n, exp_oe(1));
    chk({req, " out narrow"}, out_n, exp_out(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; reg_sel = 2'd0; wdata = 8'h00; pin_in = 8'hA5;
    for (int k = 0; k < 2; k++) begin md[k] = 0; mdir[k] = 0; mmode[k] = 0; end
    pinv = 8'h00;
    repeat (3) @(negedge clk);
    // R8: state while in reset (synchroniser cleared, so data reads 0)
    reg_sel = 2'd0; #1;
    chk("R8 data", rd_w, 8'h00);
    chk("R8 oe", oe_w, 8'h00);
    chk("R9 fixed in reset", rd_n, 8'hF0);
    reg_sel = 2'd1; #1; chk("R8 dir", rd_w, 8'h00);
    reg_sel = 2'd2; #1; chk("R8 mode", rd_w, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pinv = 8'hA5;
    check_all("R8 after release");

    // R1/R3/R7: latch written while pins are inputs; reads show pins
    wr(0, 8'h3C);
    check_all("R1 R3 R7 input write");
    set_pins(8'h5A);
    check_all("R3 input pin change");
    // R2/R5: turn to push-pull outputs, latch now visible
    wr(1, 8'hFF);
    check_all("R1 R2 R5 push-pull");
    // R4/R6: lower nibble open-drain
    wr(2, 8'h0F);
    check_all("R4 R6 open-drain mix");
    // R10: read during write returns old value
    wr(2, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd0; wdata = 8'hC3;
    #1 chk("R10 same-cycle old", rd_w, md[0]);
    @(posedge clk);
    md[0] = 8'hC3; md[1] = 8'h03;
    #1 wr_en = 1'b0;
    @(negedge clk);
    #1 chk("R10 next read new", rd_w, 8'hC3);
    // R11: reg_sel 3 ignored
    wr(3, 8'h55);
    check_all("R11 unused select");
    // R9: narrow port upper bits
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hF8);
    check_all("R9 unimplemented bits");
    // R3 latency: pin change visible only after two edges
    wr(1, 8'h00);
    @(negedge clk); pin_in = 8'hFF;
    reg_sel = 2'd0;
    @(negedge clk); #1 chk("R3 one edge old", rd_w, pinv);
    @(negedge clk); #1 chk("R3 two edges new", rd_w, 8'hFF);
    pinv = 8'hFF;

    for (int it = 0; it < 300; it++) begin
      int s;
      s = int'($urandom_range(0, 3));
      wr(s, 8'($urandom()));
      if ($urandom_range(0, 2) == 0) set_pins(8'($urandom()));
      check_all("R1 R2 R4 R5 R6 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule